// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block turns one free-running basic clock of nominally 19.2 MHz into the three timing signals a PCM codec link needs. These are a 256 kHz bit clock, an 8 kHz frame sync and a gated copy of the basic clock for neighbouring devices. The bit clock is an odd divide-by-75 of the basic clock. The frame sync is a one-bit-period pulse that repeats every 32 bit clocks and is aligned to a rising bit clock edge.

Power-down is active low. While it is asserted, the divider chain is parked and all three outputs are held low. When it is released, the chain starts again from the top of a frame. The block-level reset deliberately does not touch this generator: codecs that share the clock keep their timing while the rest of the device is reset. The divider state is defined by power-down alone, so power-down must be held for at least one basic clock edge after power-up. Before that edge the outputs are undefined.

Top module: `pcm_clkgen`

## Requirements
- R1: While pwrdn_n is high, mclk_o equals clk_i from the first falling clock edge after pwrdn_n went high.
- R2: While running, bclk_o repeats every 75 basic clock cycles, high for 37 cycles and low for 38.
- R3: While running, fsync_o rises once every 32 bit clock periods (2400 basic clock cycles).
- R4: Each fsync_o pulse stays high for exactly one bit clock period (75 basic clock cycles).
- R5: fsync_o changes level only on a basic clock edge at which bclk_o rises.
- R6: One rising clock edge after pwrdn_n is sampled low, bclk_o and fsync_o are low. From the first falling clock edge after pwrdn_n went low, mclk_o is held low. All three stay low while pwrdn_n stays low.
- R7: On the first rising clock edge that samples pwrdn_n high after power-down, bclk_o and fsync_o both go high together, and the 75-cycle and 2400-cycle sequences restart from that edge.
- R8: rst_n has no effect on any output: mclk_o, bclk_o and fsync_o keep their sequence through any reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Basic clock, nominally 19.2 MHz |
| rst_n | input | 1 | Device reset, active low; ignored by the generator |
| pwrdn_n | input | 1 | Power-down, active low; parks the dividers and forces outputs low |
| mclk_o | output | 1 | Gated copy of the basic clock |
| bclk_o | output | 1 | PCM bit clock, basic clock divided by 75 |
| fsync_o | output | 1 | Frame sync, one bit period high every 32 bit periods |

## Verification
A corrupted bit divider count shows up within one bit period as a high or low phase of the wrong length on bclk_o. A frame counter that slips shows up as fsync_o rising at the wrong bit clock, at the latest one frame (2400 cycles) later. A parking state on power-down that is not restored shows up on the very first edge after release, as bclk_o and fsync_o failing to rise together. A broken gate enable shows up within half a clock as mclk_o high during power-down or missing pulses while running.

// File: rtl/pcmclk_pkg.sv
// Package: shared constants for the PCM clock and frame generator.
// Assumes a 19.2 MHz basic clock; all ratios below derive 256 kHz and 8 kHz.
package pcmclk_pkg;
    // Basic clock cycles per bit clock period
    localparam int unsigned BIT_DIV      = 75;
    // Basic clock cycles the bit clock spends high (remainder is low)
    localparam int unsigned BIT_HIGH     = 37;
    // Bit clock periods per frame
    localparam int unsigned FRAME_BITS   = 32;
    // Bit clock periods the frame sync stays high
    localparam int unsigned SYNC_BITS    = 1;
endpackage

// File: rtl/pcmclk_bit_div.sv
// Module: bit clock divider.
// Divides the basic clock by DIV and produces a registered bit clock that is high
// for the first HIGH counts of each period. While run is low the counter parks
// at its last value so the first running edge starts a fresh period.
module pcmclk_bit_div #(
    parameter int unsigned DIV  = 75,
    parameter int unsigned HIGH = 37
) (
    input  logic clk_i,
    input  logic run_i,
    output logic bclk_o,
    output logic wrap_o
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
    localparam logic [CW-1:0] HI_LIM = CW'(HIGH);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          bclk_q;

    // Next count value: wrap to zero after the last count of a period
    always_comb begin
        cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Count and shape the bit clock; park at the last count while stopped
    always_ff @(posedge clk_i) begin
        if (!run_i) begin
            cnt_q  <= LAST;
            bclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            bclk_q <= (cnt_nxt < HI_LIM);
        end
    end

    assign bclk_o = bclk_q;
    assign wrap_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pcmclk_frame_cnt.sv
// Module: frame counter.
// Counts bit clock periods using the divider's wrap strobe and raises the frame
// sync for the first SYNC bits of each FRAME-bit frame. Because it only moves
// on a wrap, the sync changes on the same edge that raises the bit clock.
module pcmclk_frame_cnt #(
    parameter int unsigned FRAME = 32,
    parameter int unsigned SYNC  = 1
) (
    input  logic clk_i,
    input  logic run_i,
    input  logic wrap_i,
    output logic fsync_o
);
    localparam int unsigned FW = $clog2(FRAME);
    localparam logic [FW-1:0] LAST    = FW'(FRAME - 1);
    localparam logic [FW-1:0] SYNC_LIM = FW'(SYNC);

    logic [FW-1:0] bit_q;
    logic [FW-1:0] bit_nxt;
    logic          fsync_q;

    // Next bit index within the frame
    always_comb begin
        bit_nxt = (bit_q == LAST) ? '0 : bit_q + 1'b1;
    end

    // Advance once per bit period and place the sync at the head of the frame
    always_ff @(posedge clk_i) begin
        if (!run_i) begin
            bit_q   <= LAST;
            fsync_q <= 1'b0;
        end else if (wrap_i) begin
            bit_q   <= bit_nxt;
            fsync_q <= (bit_nxt < SYNC_LIM);
        end
    end

    assign fsync_o = fsync_q;
endmodule

// File: rtl/pcmclk_mclk_gate.sv
// Module: master clock output gate.
// Passes the basic clock through an AND gate whose enable is captured on the
// falling edge, so the enable only changes while the clock is low and the
// output never carries a shortened pulse.
module pcmclk_mclk_gate (
    input  logic clk_i,
    input  logic run_i,
    output logic mclk_o
);
    logic en_q;

    // Capture the enable in the low phase of the clock
    always_ff @(negedge clk_i) begin
        en_q <= run_i;
    end

    assign mclk_o = clk_i & en_q;
endmodule

// File: rtl/pcm_clkgen.sv
// Module: PCM clock and frame generator (top).
// Derives the bit clock, frame sync and gated master clock from the basic clock.
// Assumes pwrdn_n is held low for at least one clock edge after power-up; that
// edge defines all divider state. rst_n is not used by the generator logic so
// the outputs run through a device reset.
module pcm_clkgen #(
    parameter int unsigned BIT_DIV    = pcmclk_pkg::BIT_DIV,
    parameter int unsigned BIT_HIGH   = pcmclk_pkg::BIT_HIGH,
    parameter int unsigned FRAME_BITS = pcmclk_pkg::FRAME_BITS,
    parameter int unsigned SYNC_BITS  = pcmclk_pkg::SYNC_BITS
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic pwrdn_n,
    output logic mclk_o,
    output logic bclk_o,
    output logic fsync_o
);
    logic bit_wrap;

    pcmclk_bit_div #(
        .DIV  (BIT_DIV),
        .HIGH (BIT_HIGH)
    ) bit_div_i (
        .clk_i  (clk_i),
        .run_i  (pwrdn_n),
        .bclk_o (bclk_o),
        .wrap_o (bit_wrap)
    );

    pcmclk_frame_cnt #(
        .FRAME (FRAME_BITS),
        .SYNC  (SYNC_BITS)
    ) frame_cnt_i (
        .clk_i   (clk_i),
        .run_i   (pwrdn_n),
        .wrap_i  (bit_wrap),
        .fsync_o (fsync_o)
    );

    pcmclk_mclk_gate mclk_gate_i (
        .clk_i  (clk_i),
        .run_i  (pwrdn_n),
        .mclk_o (mclk_o)
    );
endmodule

// File: rtl/pcm_clkgen_chk.sv
// Module: checker for the PCM clock and frame generator.
// Measures phase lengths with its own counters (cleared in power-down) and
// relates them to the output edges. Attached to the top module by bind below.
module pcm_clkgen_chk #(
    parameter int unsigned BIT_DIV    = 75,
    parameter int unsigned BIT_HIGH   = 37,
    parameter int unsigned FRAME_BITS = 32,
    parameter int unsigned SYNC_BITS  = 1
) (
    input logic clk_i,
    input logic rst_n,
    input logic pwrdn_n,
    input logic bclk_o,
    input logic fsync_o
);
    localparam int unsigned FRAME_CYC = BIT_DIV * FRAME_BITS;
    localparam int unsigned SYNC_CYC  = BIT_DIV * SYNC_BITS;

    int unsigned hi_len, lo_len, fs_hi, fs_per;
    logic        bclk_d, fsync_d, b_primed, f_primed;

    // Track phase lengths of the outputs while running
    always_ff @(posedge clk_i) begin
        if (!pwrdn_n) begin
            hi_len <= 0; lo_len <= 0; fs_hi <= 0; fs_per <= 0;
            bclk_d <= 1'b0; fsync_d <= 1'b0; b_primed <= 1'b0; f_primed <= 1'b0;
        end else begin
            bclk_d  <= bclk_o;
            fsync_d <= fsync_o;
            hi_len  <= bclk_o ? hi_len + 1 : 0;
            lo_len  <= bclk_o ? 0 : lo_len + 1;
            fs_hi   <= fsync_o ? fs_hi + 1 : 0;
            fs_per  <= (fsync_o && !fsync_d) ? 1 : fs_per + 1;
            if (!bclk_o && bclk_d) b_primed <= 1'b1;
            if (fsync_o && !fsync_d) f_primed <= 1'b1;
        end
    end

    AST_BCLK_HIGH_LEN: assert property (@(posedge clk_i) disable iff (!rst_n || !pwrdn_n)
        $fell(bclk_o) |-> hi_len == BIT_HIGH); // R2
    AST_BCLK_LOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_n || !pwrdn_n)
        (b_primed && $rose(bclk_o)) |-> lo_len == BIT_DIV - BIT_HIGH); // R2
    AST_FSYNC_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_n || !pwrdn_n)
        (f_primed && $rose(fsync_o)) |-> fs_per == FRAME_CYC); // R3
    AST_FSYNC_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_n || !pwrdn_n)
        $fell(fsync_o) |-> fs_hi == SYNC_CYC); // R4
    AST_FSYNC_ON_BCLK_RISE: assert property (@(posedge clk_i) disable iff (!rst_n || !pwrdn_n)
        !$stable(fsync_o) |-> $rose(bclk_o)); // R5
    AST_PWRDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
        !pwrdn_n |=> (!bclk_o && !fsync_o)); // R6
endmodule

bind pcm_clkgen pcm_clkgen_chk #(
    .BIT_DIV    (BIT_DIV),
    .BIT_HIGH   (BIT_HIGH),
    .FRAME_BITS (FRAME_BITS),
    .SYNC_BITS  (SYNC_BITS)
) chk_i (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .pwrdn_n (pwrdn_n),
    .bclk_o  (bclk_o),
    .fsync_o (fsync_o)
);

// File: tb/pcm_clkgen_tb_top.sv
// Bench: sweeps every basic clock cycle over two full power-up runs and compares
// the outputs with values computed from the cycle index since release.
module pcm_clkgen_tb_top;
    logic clk_i = 1'b0;
    logic rst_n;
    logic pwrdn_n;
    logic mclk_o, bclk_o, fsync_o;
    int   n_chk = 0;
    int   n_bad = 0;

    always #5 clk_i = ~clk_i;

    pcm_clkgen dut_i (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .pwrdn_n (pwrdn_n),
        .mclk_o  (mclk_o),
        .bclk_o  (bclk_o),
        .fsync_o (fsync_o)
    );

    // Compare one output bit and report a mismatch
    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Power-down cycles: everything low (mclk checked from the second high phase)
    task automatic pd_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_i); #2;
            chk(bclk_o, 1'b0, "R6", "bclk in power-down");
            chk(fsync_o, 1'b0, "R6", "fsync in power-down");
            if (i > 0) chk(mclk_o, 1'b0, "R6", "mclk high phase in power-down");
            #5;
            chk(mclk_o, 1'b0, "R6", "mclk low phase in power-down");
        end
    endtask

    // Running cycles k = 0..n-1 after release; rst_n low for edges in [rlo, rhi)
    task automatic run_sweep(input int n, input int rlo, input int rhi);
        logic pb = 1'b0;
        logic pf = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic  eb, ef, in_rst;
            string rb, rf;
            @(posedge clk_i); #2;
            eb = ((k % 75) < 37);
            ef = (((k / 75) % 32) == 0);
            in_rst = (k >= rlo) && (k < rhi);
            rb = (k == 0) ? "R7" : (in_rst ? "R8" : "R2");
            rf = (k == 0) ? "R7" : (in_rst ? "R8" : (ef ? "R4" : "R3"));
            chk(bclk_o, eb, rb, "bclk level");
            chk(fsync_o, ef, rf, "fsync level");
            if (k >= 1) chk(mclk_o, 1'b1, in_rst ? "R8" : "R1", "mclk high phase");
            if (k > 0 && fsync_o !== pf)
                chk(bclk_o && !pb, 1'b1, "R5", "fsync moved without bclk rise");
            pb = bclk_o;
            pf = fsync_o;
            #5;
            chk(mclk_o, 1'b0, "R1", "mclk low phase");
            rst_n = !(((k + 1) >= rlo) && ((k + 1) < rhi));
        end
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        pwrdn_n = 1'b0;
        pd_cycles(4);
        pwrdn_n = 1'b1;
        rst_n   = 1'b1;
        run_sweep(5400, 3000, 3030);
        pwrdn_n = 1'b0;
        pd_cycles(6);
        pwrdn_n = 1'b1;
        run_sweep(2500, -1, -1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule